// File: doc/BRIEF.md
# Complex 4x4 Matrix Product Engine

This block multiplies two square matrices whose elements are complex fixed-point numbers with signed 16-bit real and imaginary parts. Software or a host state machine fills both operands element by element through a single write port. One pulse on `start` then launches the computation. Each result element (i,j) is the complex dot product of row i of the left operand with column j of the right operand.

The datapath forms all four complex products of one dot product in parallel, using four real multiplies per product, and reduces them through a registered adder tree. Once the pipeline is full, one finished result element leaves per clock. Results stream out in row-major order: i is the outer index and j the inner one. They carry full precision, so no rounding, saturation or wrap-around ever occurs. A smaller matrix, such as 3x3, is handled by padding the unused rows and columns with zeros.

Top module: `cplx_matmul`

## Requirements
- R1: After a synchronous reset, `busy` and `out_valid` are 0, and `out_re` and `out_im` are 0.
- R2: When `wr_en` is 1 at a clock edge, the element given by `wr_re`/`wr_im` is stored. It goes to the left operand when `wr_sel`=0 and to the right operand when `wr_sel`=1. The row is `wr_addr[3:2]` and the column is `wr_addr[1:0]`.
- R3: A `start` sampled while `busy` is 0 begins a computation. `busy` is 1 from the following cycle through the cycle of the last result, and it falls together with `out_valid`.
- R4: If `start` is accepted at clock edge E, `out_valid` first rises after edge E+6.
- R5: Each accepted start yields exactly 16 consecutive `out_valid` cycles. They carry elements (0,0),(0,1),...,(3,3) in row-major order.
- R6: Each result element is the sum over k of A[i][k]·B[k][j]. Each complex product is computed as real = ar·br − ai·bi and imaginary = ar·bi + ai·br.
- R7: The output components are 35-bit signed two's-complement values, exact for all operand values including −32768, with no rounding and no saturation.
- R8: Each element's sum starts from zero: results of a run depend only on the operands present at that run and never on earlier runs.
- R9: A `start` sampled while `busy` is 1 is ignored, and no extra results follow the current run.
- R10: While `out_valid` is 0, `out_re` and `out_im` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 1 | Operand select: 0 left (A), 1 right (B) |
| wr_addr | input | 4 | Element index: row in [3:2], column in [1:0] |
| wr_re | input | 16 | Real part of the element being written |
| wr_im | input | 16 | Imaginary part of the element being written |
| start | input | 1 | Launch request, one cycle |
| busy | output | 1 | Computation in progress |
| out_valid | output | 1 | Result element present on the outputs |
| out_re | output | 35 | Real part of the result element |
| out_im | output | 35 | Imaginary part of the result element |

## Verification
The checker assumes the operand store is left alone while `busy` is high. Rewriting an element mid-run would mix the old and new matrices within one result stream. The bench therefore issues every write only while the block is idle.

The bench treats `start` as unconstrained. It deliberately pulses `start` in the middle of a run to show that the 16-cycle burst is neither restarted nor extended. The checks in the bench cover the arithmetic with:
- the zero-padded 3x3 real vector,
- identity operands,
- pseudo-random complex matrices,
- all-extreme operand values.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
  typedef enum logic {
    MAT_A = 1'b0,
    MAT_B = 1'b1
  } mat_sel_e;

  // Exact width of an N-term complex dot product of DW-bit operands:
  // 2*DW for the product, +1 for the add/sub of two products, +log2(N) for the sum
  function automatic int acc_width(input int dw, input int n);
    return 2 * dw + 1 + $clog2(n);
  endfunction
endpackage

// File: rtl/cmm_opstore.sv
module cmm_opstore
  import cmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic                       wr_sel,
  input  logic [2*$clog2(N)-1:0]     wr_addr,
  input  logic [DW-1:0]              wr_re,
  input  logic [DW-1:0]              wr_im,
  input  logic [$clog2(N)-1:0]       rd_row,
  input  logic [$clog2(N)-1:0]       rd_col,
  output logic [N-1:0][DW-1:0]       a_row_re,
  output logic [N-1:0][DW-1:0]       a_row_im,
  output logic [N-1:0][DW-1:0]       b_col_re,
  output logic [N-1:0][DW-1:0]       b_col_im
);
  localparam int LOGN = $clog2(N);
  localparam int NE   = N * N;

  logic [DW-1:0] a_re [NE];
  logic [DW-1:0] a_im [NE];
  logic [DW-1:0] b_re [NE];
  logic [DW-1:0] b_im [NE];

  // Storage has no reset, so it maps onto plain registers
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (mat_sel_e'(wr_sel) == MAT_A) begin
        a_re[wr_addr] <= wr_re;
        a_im[wr_addr] <= wr_im;
      end else begin
        b_re[wr_addr] <= wr_re;
        b_im[wr_addr] <= wr_im;
      end
    end
  end

  // N parallel reads each: a row of A, a column of B
  for (genvar k = 0; k < N; k++) begin : g_rd
    localparam logic [LOGN-1:0] KI = LOGN'(k);
    assign a_row_re[k] = a_re[{rd_row, KI}];
    assign a_row_im[k] = a_im[{rd_row, KI}];
    assign b_col_re[k] = b_re[{KI, rd_col}];
    assign b_col_im[k] = b_im[{KI, rd_col}];
  end
endmodule

// File: rtl/cmm_seq.sv
module cmm_seq #(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  drain_done,
  output logic                  busy,
  output logic                  iss_vld,
  output logic                  iss_last,
  output logic [$clog2(N)-1:0]  iss_row,
  output logic [$clog2(N)-1:0]  iss_col
);
  localparam int LOGN = $clog2(N);
  localparam int AW   = 2 * LOGN;
  localparam logic [AW-1:0] LAST_IDX = AW'(N * N - 1);

  logic          running;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      running <= 1'b1;
      cnt     <= '0;
    end else begin
      if (running) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_IDX) running <= 1'b0;
      end
      if (drain_done) busy <= 1'b0;
    end
  end

  assign iss_vld  = running;
  assign iss_last = running && (cnt == LAST_IDX);
  assign iss_row  = cnt[AW-1:LOGN];
  assign iss_col  = cnt[LOGN-1:0];
endmodule

// File: rtl/cmm_dot.sv
module cmm_dot
  import cmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_vld,
  input  logic                         in_last,
  input  logic [N-1:0][DW-1:0]         a_re,
  input  logic [N-1:0][DW-1:0]         a_im,
  input  logic [N-1:0][DW-1:0]         b_re,
  input  logic [N-1:0][DW-1:0]         b_im,
  output logic                         out_valid,
  output logic                         out_last,
  output logic [acc_width(DW, N)-1:0]  out_re,
  output logic [acc_width(DW, N)-1:0]  out_im
);
  localparam int LOGN  = $clog2(N);
  localparam int PW    = 2 * DW;
  localparam int ACC_W = acc_width(DW, N);
  localparam int LAT   = 4 + LOGN;      // operand reg, mult, combine, tree, output
  localparam int NODES = 2 * N - 1;     // heap-ordered adder tree, leaves at N-1..2N-2

  logic signed [DW-1:0] s1_ar [N];
  logic signed [DW-1:0] s1_ai [N];
  logic signed [DW-1:0] s1_br [N];
  logic signed [DW-1:0] s1_bi [N];

  logic signed [PW-1:0] p_rr [N];
  logic signed [PW-1:0] p_ii [N];
  logic signed [PW-1:0] p_ri [N];
  logic signed [PW-1:0] p_ir [N];

  logic [ACC_W-1:0] t_re [NODES];
  logic [ACC_W-1:0] t_im [NODES];

  logic [LAT-1:0] vpipe;
  logic [LAT-1:0] lpipe;

  // Stage 1: capture operands
  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      s1_ar[k] <= a_re[k];
      s1_ai[k] <= a_im[k];
      s1_br[k] <= b_re[k];
      s1_bi[k] <= b_im[k];
    end
  end

  // Stage 2: four real products per complex term
  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      p_rr[k] <= s1_ar[k] * s1_br[k];
      p_ii[k] <= s1_ai[k] * s1_bi[k];
      p_ri[k] <= s1_ar[k] * s1_bi[k];
      p_ir[k] <= s1_ai[k] * s1_br[k];
    end
  end

  // Stage 3: complex combine into leaves; following stages: one tree level per cycle.
  // Every sum is rebuilt from fresh products, so nothing carries between elements.
  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      t_re[N-1+k] <= {{(ACC_W-PW){p_rr[k][PW-1]}}, p_rr[k]}
                   - {{(ACC_W-PW){p_ii[k][PW-1]}}, p_ii[k]};
      t_im[N-1+k] <= {{(ACC_W-PW){p_ri[k][PW-1]}}, p_ri[k]}
                   + {{(ACC_W-PW){p_ir[k][PW-1]}}, p_ir[k]};
    end
    for (int n = 0; n < N - 1; n++) begin
      t_re[n] <= t_re[2*n+1] + t_re[2*n+2];
      t_im[n] <= t_im[2*n+1] + t_im[2*n+2];
    end
  end

  // Valid and last track the data through every stage
  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
      lpipe <= '0;
    end else begin
      vpipe <= {vpipe[LAT-2:0], in_vld};
      lpipe <= {lpipe[LAT-2:0], in_vld && in_last};
    end
  end

  // Output register: the tree root is valid when vpipe[LAT-2] is set
  always_ff @(posedge clk) begin
    if (rst) begin
      out_re <= '0;
      out_im <= '0;
    end else if (vpipe[LAT-2]) begin
      out_re <= t_re[0];
      out_im <= t_im[0];
    end else begin
      out_re <= '0;
      out_im <= '0;
    end
  end

  assign out_valid = vpipe[LAT-1];
  assign out_last  = lpipe[LAT-1];
endmodule

// File: rtl/cplx_matmul.sv
module cplx_matmul
  import cmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_sel,
  input  logic [2*$clog2(N)-1:0]       wr_addr,
  input  logic [DW-1:0]                wr_re,
  input  logic [DW-1:0]                wr_im,
  input  logic                         start,
  output logic                         busy,
  output logic                         out_valid,
  output logic [acc_width(DW, N)-1:0]  out_re,
  output logic [acc_width(DW, N)-1:0]  out_im
);
  localparam int LOGN = $clog2(N);

  logic                 iss_vld;
  logic                 iss_last;
  logic [LOGN-1:0]      iss_row;
  logic [LOGN-1:0]      iss_col;
  logic                 res_last;
  logic [N-1:0][DW-1:0] ar;
  logic [N-1:0][DW-1:0] ai;
  logic [N-1:0][DW-1:0] br;
  logic [N-1:0][DW-1:0] bi;

  cmm_seq #(.N(N)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .drain_done (out_valid && res_last),
    .busy       (busy),
    .iss_vld    (iss_vld),
    .iss_last   (iss_last),
    .iss_row    (iss_row),
    .iss_col    (iss_col)
  );

  cmm_opstore #(.N(N), .DW(DW)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_addr  (wr_addr),
    .wr_re    (wr_re),
    .wr_im    (wr_im),
    .rd_row   (iss_row),
    .rd_col   (iss_col),
    .a_row_re (ar),
    .a_row_im (ai),
    .b_col_re (br),
    .b_col_im (bi)
  );

  cmm_dot #(.N(N), .DW(DW)) u_dot (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (iss_vld),
    .in_last   (iss_last),
    .a_re      (ar),
    .a_im      (ai),
    .b_re      (br),
    .b_im      (bi),
    .out_valid (out_valid),
    .out_last  (res_last),
    .out_re    (out_re),
    .out_im    (out_im)
  );
endmodule

// File: rtl/cplx_matmul_chk.sv
module cplx_matmul_chk
  import cmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         start,
  input logic                         busy,
  input logic                         out_valid,
  input logic [acc_width(DW, N)-1:0]  out_re,
  input logic [acc_width(DW, N)-1:0]  out_im
);
  localparam int LAT = 4 + $clog2(N);
  localparam int NE  = N * N;
  localparam int CW  = $clog2(NE) + 1;

  logic [7:0]    lat_cnt;
  logic [CW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      vcnt    <= '0;
    end else if (start && !busy) begin
      lat_cnt <= 8'd1;
      vcnt    <= '0;
    end else begin
      if (lat_cnt != 8'hFF) lat_cnt <= lat_cnt + 8'd1;
      if (out_valid) vcnt <= vcnt + 1'b1;
    end
  end

  // R3
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(out_valid));

  // R4
  first_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (lat_cnt == 8'(LAT + 1)));

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> (vcnt == CW'(NE)));

  // R9
  burst_gapless_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (vcnt < CW'(NE - 1))) |=> out_valid);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_re == '0 && out_im == '0));
endmodule

bind cplx_matmul cplx_matmul_chk #(.N(N), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/cplx_matmul_tb.sv
`timescale 1ns/1ps
module cplx_matmul_tb;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 35;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [DW-1:0] wr_re = '0;
  logic [DW-1:0] wr_im = '0;
  logic          start = 1'b0;
  logic          busy;
  logic          out_valid;
  logic [AW-1:0] out_re;
  logic [AW-1:0] out_im;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int ma_re [16];
  int ma_im [16];
  int mb_re [16];
  int mb_im [16];
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  cplx_matmul #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_re(wr_re), .wr_im(wr_im), .start(start), .busy(busy),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic load_all();
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 16; e++) begin
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = s[0];
        wr_addr = e[3:0];
        wr_re   = (s == 0) ? ma_re[e][15:0] : mb_re[e][15:0];
        wr_im   = (s == 0) ? ma_im[e][15:0] : mb_im[e][15:0];
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic longint exp_re(input int i, input int j);
    longint acc = 0;
    for (int k = 0; k < 4; k++)
      acc += longint'(ma_re[i*4+k]) * mb_re[k*4+j] - longint'(ma_im[i*4+k]) * mb_im[k*4+j];
    return acc;
  endfunction

  function automatic longint exp_im(input int i, input int j);
    longint acc = 0;
    for (int k = 0; k < 4; k++)
      acc += longint'(ma_re[i*4+k]) * mb_im[k*4+j] + longint'(ma_im[i*4+k]) * mb_re[k*4+j];
    return acc;
  endfunction

  // Start accepted at edge E0; after edge Ek the bench samples at the negedge.
  task automatic run_check(input string req, input bit poke_busy);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && out_valid == 1'b0, "R3 busy after start", busy, 1);
    for (int k = 1; k <= 24; k++) begin
      start = poke_busy && (k == 8);
      @(negedge clk);
      if (k < 6) begin
        check(out_valid == 1'b0, "R4 no early result", out_valid, 0);
      end else if (k <= 21) begin
        int e = k - 6;
        longint ar = longint'($signed(out_re));
        longint ai = longint'($signed(out_im));
        check(out_valid == 1'b1, "R5 valid in burst", out_valid, 1);
        check(ar == exp_re(e / 4, e % 4), {req, " real"}, ar, exp_re(e / 4, e % 4));
        check(ai == exp_im(e / 4, e % 4), {req, " imag"}, ai, exp_im(e / 4, e % 4));
        if (k == 21) check(busy == 1'b1, "R3 busy on last result", busy, 1);
      end else begin
        check(out_valid == 1'b0 && busy == 1'b0,
              poke_busy ? "R9 no extra results" : "R5 burst ends", out_valid, 0);
        check(out_re == '0 && out_im == '0, "R10 idle outputs zero",
              longint'($signed(out_re)), 0);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(busy == 1'b0 && out_valid == 1'b0, "R1 reset flags", busy, 0);
    check(out_re == '0 && out_im == '0, "R1 reset outputs", longint'($signed(out_re)), 0);

    // R6 / R2: zero-padded 3x3 real vector (first row 870 906 942)
    for (int e = 0; e < 16; e++) begin
      ma_re[e] = 0; ma_im[e] = 0; mb_re[e] = 0; mb_im[e] = 0;
    end
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        ma_re[i*4+j] = 11 + i*3 + j;
        mb_re[i*4+j] = 21 + i*3 + j;
      end
    check(exp_re(0, 0) == 870 && exp_re(2, 2) == 1410, "R6 bench model", exp_re(0, 0), 870);
    load_all();
    run_check("R6 padded 3x3", 1'b0);

    // R6: complex A times identity B gives A
    for (int e = 0; e < 16; e++) begin
      ma_re[e] = rnd16(); ma_im[e] = rnd16();
      mb_re[e] = (e / 4 == e % 4) ? 1 : 0; mb_im[e] = 0;
    end
    load_all();
    run_check("R6 identity", 1'b0);

    // R8 / R9: pseudo-random complex sweeps, one with a start poked mid-run
    for (int t = 0; t < 6; t++) begin
      for (int e = 0; e < 16; e++) begin
        ma_re[e] = rnd16(); ma_im[e] = rnd16(); mb_re[e] = rnd16(); mb_im[e] = rnd16();
      end
      load_all();
      run_check("R8 random fresh sums", t == 2);
    end

    // R7: extremes, all sign patterns that maximize magnitude
    for (int t = 0; t < 4; t++) begin
      for (int e = 0; e < 16; e++) begin
        ma_re[e] = -32768;
        ma_im[e] = (t[0]) ? 32767 : -32768;
        mb_re[e] = (t[1]) ? 32767 : -32768;
        mb_im[e] = -32768;
      end
      load_all();
      run_check("R7 full precision", 1'b0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule